// File: doc/BRIEF.md
# Transceiver Operating-Mode Controller

This block chooses the operating mode of a low-power bus transceiver. It keeps one of six modes: power-up, normal, receive-only, standby, go-to-sleep and sleep. The mode follows two control pins driven by the protocol controller and four condition flags from the supply and event monitors: core or logic supply undervoltage, battery undervoltage, battery connection (power-up) and wake-up. From the current mode it drives the enables for the transmitter, the receiver, the split-voltage common-mode output and the regulator inhibit output.

The two control pins cross clock domains, so each passes through a synchronizer before use. The flags are taken as already synchronous. Sleep is never entered straight from the pins. The pins must first select go-to-sleep, and must then hold that selection for `HOLD_CYCLES` clock cycles with no wake-up or power-up flag set. A supply undervoltage forces sleep at once. A set power-up flag masks the supply undervoltage, so that the regulators stay on after the battery is connected.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mode_o` is 6'b000001 (power-up). The inhibit enable is high and the transmitter, receiver and split enables are low. `mode_o` bit order is: 0 power-up, 1 normal, 2 receive-only, 3 standby, 4 go-to-sleep, 5 sleep.
- R2: When both synchronized pins are high, the mode becomes normal (bit 1). The transmitter, receiver, split and inhibit enables are then all high. A pin change reaches the mode on the third rising edge after it is sampled.
- R3: When the standby pin is high and the enable pin is low, the mode becomes receive-only (bit 2). In this mode the transmitter is off, and the receiver, split and inhibit enables are high.
- R4: When the standby pin is low and either the enable pin is low or the wake-up or power-up flag is set, the mode becomes standby (bit 3). Only the inhibit enable is high. The exception is a controller in sleep with no wake-up flag, which stays in sleep.
- R5: When the standby pin is low, the enable pin is high and neither the wake-up nor the power-up flag is set, the mode becomes go-to-sleep (bit 4), with the same outputs as standby. After exactly `HOLD_CYCLES` cycles in go-to-sleep the mode becomes sleep. If a wake-up or power-up flag is set before that, the mode returns to standby and the hold count restarts.
- R6: In sleep (bit 5) all four enables are low, including the inhibit enable. Sleep holds while the standby pin stays low and no wake-up flag is set.
- R7: A supply undervoltage flag with the power-up flag clear forces sleep on the next edge from any mode. Only a battery undervoltage takes precedence.
- R8: A controller in sleep leaves it on a wake-up flag or on the standby pin going high, and then takes the mode the pins select. The standby pin cannot bring it out of sleep while the supply undervoltage flag is set (unmasked).
- R9: A battery undervoltage flag forces standby on the next edge and overrides every other input. When the flag clears, the mode follows the pins again.
- R10: While the power-up flag is set, the supply undervoltage flag has no effect on the mode. `uv_clr_o` is high whenever both flags are set, to request that the undervoltage flag be cleared.
- R11: `pwrup_clr_o` is high for exactly the one cycle in which the mode has just become normal, to request that the power-up flag be cleared.
- R12: Exactly one bit of `mode_o` is set on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Standby control pin, asynchronous; high = active modes |
| en_i | input | 1 | Enable control pin, asynchronous |
| uv_supply_i | input | 1 | Core/logic supply undervoltage flag |
| uv_batt_i | input | 1 | Battery undervoltage flag |
| pwrup_i | input | 1 | Power-up (battery connection) flag |
| wake_i | input | 1 | Wake-up flag |
| mode_o | output | 6 | One-hot mode vector |
| inh_en_o | output | 1 | Regulator inhibit output enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| split_en_o | output | 1 | Split-voltage output enable |
| pwrup_clr_o | output | 1 | One-cycle request to clear the power-up flag |
| uv_clr_o | output | 1 | Request to clear the supply undervoltage flag |

## Verification
The assertions check on every cycle that the mode stays one-hot and that the enables stay consistent with each other. They also check the forcing rules that take effect on the next edge: battery undervoltage to standby, unmasked supply undervoltage to sleep, aborting go-to-sleep to standby, and keeping sleep. The entry pulse for normal mode is checked the same way. The hold time before sleep, the three-edge latency through the pin synchronizers and the rule that undervoltage blocks the exit from sleep involve counts and sequences. Only the bench scenarios can show these, by comparing every cycle against a reference model that also tracks the synchronizer delay.

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl #(
  parameter int HOLD_CYCLES = 1750,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_i,
  input  logic       en_i,
  input  logic       uv_supply_i,
  input  logic       uv_batt_i,
  input  logic       pwrup_i,
  input  logic       wake_i,
  output logic [5:0] mode_o,
  output logic       inh_en_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       split_en_o,
  output logic       pwrup_clr_o,
  output logic       uv_clr_o
);
  localparam int PWR = 0, NRM = 1, RXO = 2, SBY = 3, GTS = 4, SLP = 5;
  localparam int CW  = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] stb_sh, en_sh;
  logic                   stb_s, en_s;
  logic [5:0]             st_q, st_d;
  logic [CW-1:0]          cnt_q;
  logic                   was_nrm_q;
  logic                   uv_eff, evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sh <= '0;
      en_sh  <= '0;
    end else begin
      stb_sh <= {stb_sh[SYNC_STAGES-2:0], stb_i};
      en_sh  <= {en_sh[SYNC_STAGES-2:0], en_i};
    end
  end

  assign stb_s  = stb_sh[SYNC_STAGES-1];
  assign en_s   = en_sh[SYNC_STAGES-1];
  assign uv_eff = uv_supply_i & ~pwrup_i;
  assign evt    = wake_i | pwrup_i;

  always_comb begin
    st_d = '0;
    if (uv_batt_i)                          st_d[SBY] = 1'b1;
    else if (uv_eff)                        st_d[SLP] = 1'b1;
    else if (st_q[SLP] && !wake_i && !stb_s) st_d[SLP] = 1'b1;
    else if (stb_s)                         st_d[en_s ? NRM : RXO] = 1'b1;
    else if (!en_s || evt)                  st_d[SBY] = 1'b1;
    else if (st_q[GTS] && cnt_q == LAST)    st_d[SLP] = 1'b1;
    else                                    st_d[GTS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= 6'b000001;
      cnt_q     <= '0;
      was_nrm_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= (st_q[GTS] && st_d[GTS]) ? cnt_q + 1'b1 : '0;
      was_nrm_q <= st_q[NRM];
    end
  end

  assign mode_o      = st_q;
  assign inh_en_o    = ~st_q[SLP];
  assign tx_en_o     = st_q[NRM];
  assign rx_en_o     = st_q[NRM] | st_q[RXO];
  assign split_en_o  = st_q[NRM] | st_q[RXO];
  assign pwrup_clr_o = st_q[NRM] & ~was_nrm_q;
  assign uv_clr_o    = uv_supply_i & pwrup_i;

  // R12
  onehot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_o) == 1);
  // R2
  tx_implies_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (rx_en_o && split_en_o && inh_en_o));
  // R9
  batt_uv_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_batt_i |=> mode_o[SBY]);
  // R7
  supply_uv_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_supply_i && !pwrup_i && !uv_batt_i) |=> mode_o[SLP]);
  // R5
  gts_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[GTS] && evt && !uv_batt_i && !uv_eff && !stb_s) |=> mode_o[SBY]);
  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[SLP] && !wake_i && !stb_s && !uv_batt_i) |=> mode_o[SLP]);
  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o[SLP]) |-> ($past(mode_o[GTS]) || $past(uv_eff)));
  // R11
  pwrup_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_clr_o |=> !pwrup_clr_o);
endmodule

// File: tb/xcvr_mode_ctrl_test.sv
module xcvr_mode_ctrl_test;
  localparam int HOLD = 12;
  localparam logic [5:0] M_PWR = 6'b000001, M_NRM = 6'b000010, M_RXO = 6'b000100,
                         M_SBY = 6'b001000, M_GTS = 6'b010000, M_SLP = 6'b100000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, stb, en, uvs, uvb, pu, wk;
  logic [5:0] mode;
  logic inh, tx, rx, split, pclr, uvclr;

  xcvr_mode_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .en_i(en), .uv_supply_i(uvs),
    .uv_batt_i(uvb), .pwrup_i(pu), .wake_i(wk), .mode_o(mode), .inh_en_o(inh),
    .tx_en_o(tx), .rx_en_o(rx), .split_en_o(split), .pwrup_clr_o(pclr),
    .uv_clr_o(uvclr));

  int n_chk = 0, n_fail = 0;
  logic [5:0] m_st;
  logic m_s1s, m_s1e, m_s2s, m_s2e, m_pclr;
  int m_cnt;

  function automatic logic [5:0] f_next(input logic [5:0] cur, input logic s, e,
                                        input logic us, ub, p, w, input int cnt);
    if (ub) return M_SBY;
    if (us && !p) return M_SLP;
    if (cur == M_SLP && !w && !s) return M_SLP;
    if (s) return e ? M_NRM : M_RXO;
    if (!e || w || p) return M_SBY;
    if (cur == M_GTS && cnt == HOLD - 1) return M_SLP;
    return M_GTS;
  endfunction

  function automatic string tag_of(input logic [5:0] m);
    case (m)
      M_PWR: return "R1";
      M_NRM: return "R2";
      M_RXO: return "R3";
      M_SBY: return "R4";
      M_GTS: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [5:0] em, input logic ep);
    logic [11:0] act, exp;
    act = {mode, inh, tx, rx, split, pclr, uvclr};
    exp = {em, ~em[5], em[1], em[1] | em[2], em[1] | em[2], ep, uvs & pu};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic lit(input string tag, input logic [5:0] em, input logic ep);
    chk(tag, em, ep);
  endtask

  task automatic step(input logic s, e, us, ub, p, w);
    logic [5:0] nx;
    stb = s; en = e; uvs = us; uvb = ub; pu = p; wk = w;
    nx = f_next(m_st, m_s2s, m_s2e, us, ub, p, w, m_cnt);
    m_cnt  = (nx == M_GTS && m_st == M_GTS) ? m_cnt + 1 : 0;
    m_pclr = nx[1] & ~m_st[1];
    m_s2s = m_s1s; m_s2e = m_s1e; m_s1s = s; m_s1e = e;
    m_st = nx;
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(m_st), m_st, m_pclr);
  endtask

  task automatic hold(input int n, input logic s, e, us, ub, p, w);
    for (int i = 0; i < n; i++) step(s, e, us, ub, p, w);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; stb = 0; en = 0; uvs = 0; uvb = 0; pu = 0; wk = 0;
    m_st = M_PWR; m_s1s = 0; m_s1e = 0; m_s2s = 0; m_s2e = 0; m_cnt = 0; m_pclr = 0;
    repeat (3) @(negedge clk);
    lit("R1", M_PWR, 1'b0);
    rst_n = 1'b1;

    hold(3, 1, 1, 0, 0, 1, 0);
    lit("R2", M_NRM, 1'b1);            // R11 pulse on entry
    step(1, 1, 0, 0, 0, 0);
    lit("R11", M_NRM, 1'b0);
    hold(3, 1, 0, 0, 0, 0, 0);
    lit("R3", M_RXO, 1'b0);
    hold(3, 0, 0, 0, 0, 0, 0);
    lit("R4", M_SBY, 1'b0);
    hold(3, 0, 1, 0, 0, 0, 0);
    lit("R5", M_GTS, 1'b0);
    hold(HOLD - 1, 0, 1, 0, 0, 0, 0);
    lit("R5", M_GTS, 1'b0);
    step(0, 1, 0, 0, 0, 0);
    lit("R6", M_SLP, 1'b0);
    hold(4, 0, 0, 0, 0, 0, 0);
    lit("R6", M_SLP, 1'b0);
    step(0, 0, 0, 0, 0, 1);
    lit("R8", M_SBY, 1'b0);
    hold(3, 0, 1, 0, 0, 0, 0);
    lit("R5", M_GTS, 1'b0);
    hold(2, 0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1);
    lit("R5", M_SBY, 1'b0);            // abort by wake-up
    hold(HOLD + 1, 0, 1, 0, 0, 0, 0);
    lit("R5", M_SLP, 1'b0);
    hold(4, 1, 1, 1, 0, 0, 0);
    lit("R8", M_SLP, 1'b0);            // undervoltage blocks exit
    step(1, 1, 0, 0, 0, 0);
    lit("R8", M_NRM, 1'b1);
    step(1, 1, 1, 0, 0, 0);
    lit("R7", M_SLP, 1'b0);
    step(1, 1, 1, 0, 1, 0);
    lit("R10", M_NRM, 1'b1);
    step(1, 1, 1, 1, 1, 0);
    lit("R9", M_SBY, 1'b0);
    step(1, 1, 0, 0, 0, 0);
    lit("R9", M_NRM, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      logic s, e, us, ub, p, w;
      s  = ($urandom % 16 == 0) ? ~stb : stb;
      e  = ($urandom % 12 == 0) ? ~en : en;
      us = ($urandom % 40 == 0) ? ~uvs : uvs;
      ub = ($urandom % 60 == 0) ? ~uvb : uvb;
      p  = ($urandom % 50 == 0) ? ~pu : pu;
      w  = ($urandom % 35 == 0);
      if (i % 500 < 40) begin us = 0; ub = 0; p = 0; w = 0; s = 0; e = 1; end
      step(s, e, us, ub, p, w);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule